// File: doc/BRIEF.md
# Converter Host Control Register Interface

This block sits between a host processor's parallel bus and a sampling converter. It holds two 10-bit control registers. Register 0 is a general converter setup word. Register 1 carries the buffer trigger level, the shape of the data-ready signal, the output number format, offset calibration, the bus strobe mode and a debug readback switch. Apart from debug readback, a read of address 0 returns the current sample word from the sample buffer. A read of address 1 returns register 1, with bit 1 replaced by a sticky overflow flag.

The bus strobe scheme can be changed while the block runs. In separate-strobe mode the host uses a read strobe and a write strobe. In combined mode the write pin is a read/write level (high = read, low = write), chip select acts as the strobe, and the read strobe pin has no effect. Register 1 bit 0 and bit 1 are command bits. Writing 1 to bit 0 resets the block. Writing 1 to bit 1 clears the sample buffer pointers. Neither bit is stored. The block drives the clear pulses and a sample-enable level to the converter core, which is outside this block.

Top module: `cvh_host_ctrl`

## Requirements
- R1: After reset, register 0 is 0 and register 1 holds 0x030 (bit 4 pulse type = 1, bit 5 polarity = 1, all other bits 0); `samp_en` is 0 and `rdata` is 0.
- R2: In separate-strobe mode (register 1 bit 6 = 0), an access with `cs_n` low and `wr_n` low is committed when `wr_n` or `cs_n` rises. `addr` = 0 selects register 0 and `addr` = 1 selects register 1. The new value is visible on the next cycle.
- R3: In combined mode (bit 6 = 1), `wr_n` low with `cs_n` low is a write and `wr_n` high with `cs_n` low is a read. The access completes when `cs_n` rises. `rd_n` has no effect in this mode.
- R4: Writing register 1 with bit 0 = 1 returns both registers to their R1 values, clears the overflow flag, and pulses `ptr_clr` and `ofs_clr` for one cycle. Bit 0 always reads back as 0.
- R5: Writing register 1 with bit 1 = 1 and bit 0 = 0 pulses `ptr_clr` for one cycle without `ofs_clr` and stores the other bits. Bit 1 is not stored.
- R6: A cycle with `ovf_evt` high sets the overflow flag, which reads as bit 1 of register 1. The flag clears when a read returning register 1 completes. If an overflow event arrives in the same cycle as that completion, the flag stays set.
- R7: Outside debug readback, a read at `addr` 0 returns `sample_in`, and `sample_pop` is high for the one cycle after that read completes.
- R8: Once register 1 is written with bit 9 = 1, the first completed read returns register 0 and the second returns register 1 (regardless of `addr`). Later reads follow the normal address decode. Any later write to register 1 restarts this sequence.
- R9: `samp_en` rises on the 5th clock edge after a hardware reset is released or after the edge that commits a soft reset.
- R10: `sample_pop` stays low for reads that return register contents, and `rdata` is 0 whenever no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low active; strobe in combined mode |
| rd_n | input | 1 | Read strobe, low active (separate mode only) |
| wr_n | input | 1 | Write strobe, or read/write level in combined mode |
| addr | input | 1 | Register select |
| wdata | input | 10 | Write data |
| rdata | output | 10 | Read data, 0 when idle |
| ovf_evt | input | 1 | Buffer overflow event from buffer logic |
| sample_in | input | 10 | Current sample word from the buffer |
| sample_pop | output | 1 | Advance the buffer read pointer |
| ptr_clr | output | 1 | Clear the buffer pointers (pulse) |
| ofs_clr | output | 1 | Clear the stored offset (pulse) |
| samp_en | output | 1 | Converter may write samples |
| ctl0 | output | 10 | Register 0 contents |
| trig_lvl | output | 2 | Buffer trigger level |
| av_pulse | output | 1 | Data-ready is a pulse (1) or a level (0) |
| av_high | output | 1 | Data-ready is active high |
| rw_mode | output | 1 | Combined read/write strobe mode |
| bin_fmt | output | 1 | Straight binary output (1) or two's complement (0) |
| ofs_cal | output | 1 | Offset calibration request |
| dbg_en | output | 1 | Debug readback enabled |

## Verification
The checks assume that the host never has a read and a write active in the same cycle. They also assume that all bus signals are synchronous to `clk` and that each access holds its active state for at least one cycle before it is released. The bench drives every access as one active cycle followed by a release, with all changes on the falling clock edge. In combined mode the bench raises `wr_n` and `cs_n` together, so the end of a write is never seen as the start of a read. Overflow events are driven as single-cycle pulses, and one of them is placed on the exact edge where a register-1 read completes.

// File: rtl/cvh_pkg.sv
// Package: shared constants for the converter host control interface.
// Assumes a 10-bit register width; the bit positions are fixed because
// downstream converter logic decodes them.
package cvh_pkg;
    localparam int CW    = 10;
    localparam int B_RST = 0;
    localparam int B_FLG = 1;
    localparam int B_TRG = 2;
    localparam int B_PLS = 4;
    localparam int B_POL = 5;
    localparam int B_RWM = 6;
    localparam int B_FMT = 7;
    localparam int B_CAL = 8;
    localparam int B_DBG = 9;
    localparam logic [CW-1:0] CTL1_INIT = 10'h030;

    typedef enum logic [1:0] {
        V_SAMPLE = 2'd0,
        V_REG0   = 2'd1,
        V_REG1   = 2'd2
    } view_t;
endpackage

// File: rtl/cvh_bus_decode.sv
// Bus decoder: turns chip select, strobes and the mode bit into read/write
// activity flags and one-cycle end-of-access events. Holds the address and
// data seen during the last active cycle.
// Assumes bus inputs are synchronous to clk and that the host never has a
// read and a write active together.
module cvh_bus_decode #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rw_mode,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_act,
    output logic          rd_end,
    output logic          wr_end,
    output logic          hold_addr,
    output logic [DW-1:0] hold_data
);
    logic wr_act;
    logic rd_q;
    logic wr_q;

    // Decode the active access for the current strobe mode.
    always_comb begin
        rd_act = ~cs_n & (rw_mode ? wr_n : ~rd_n);
        wr_act = ~cs_n & ~wr_n;
    end

    // Remember last cycle's activity and the bus contents while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            hold_addr <= 1'b0;
            hold_data <= '0;
        end else begin
            rd_q <= rd_act;
            wr_q <= wr_act;
            if (rd_act || wr_act) begin
                hold_addr <= addr;
                hold_data <= wdata;
            end
        end
    end

    // An access ends in the first cycle it is no longer active.
    always_comb begin
        rd_end = rd_q & ~rd_act;
        wr_end = wr_q & ~wr_act;
    end

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_act && wr_act));
    a_r2_single_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> !wr_end);
endmodule

// File: rtl/cvh_ctrl_regs.sv
// Control register file: stores both registers, runs the command bits
// (soft reset, buffer clear), the sticky overflow flag and the
// post-reset sample-enable delay.
// Assumes wr_end is a single-cycle event with stable hold_addr/hold_data.
module cvh_ctrl_regs
    import cvh_pkg::*;
#(
    parameter int DW         = CW,
    parameter int START_WAIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_end,
    input  logic          wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          ovf_evt,
    input  logic          flag_clr,
    output logic [DW-1:0] ctl0,
    output logic [DW-1:0] ctl1,
    output logic          ovf_flag,
    output logic          ptr_clr,
    output logic          ofs_clr,
    output logic          samp_en
);
    localparam int CNTW = $clog2(START_WAIT + 1);
    localparam logic [CNTW-1:0] CNT_TOP = CNTW'(START_WAIT);

    logic            wr_r1;
    logic            do_rst;
    logic            do_fclr;
    logic [CNTW-1:0] cnt;

    // Classify the committing write.
    always_comb begin
        wr_r1   = wr_end & wr_addr;
        do_rst  = wr_r1 & wr_data[B_RST];
        do_fclr = wr_r1 & wr_data[B_FLG] & ~wr_data[B_RST];
    end

    // Register storage and command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0    <= '0;
            ctl1    <= CTL1_INIT;
            ptr_clr <= 1'b0;
            ofs_clr <= 1'b0;
        end else begin
            ptr_clr <= do_rst | do_fclr;
            ofs_clr <= do_rst;
            if (do_rst) begin
                ctl0 <= '0;
                ctl1 <= CTL1_INIT;
            end else if (wr_end && !wr_addr) begin
                ctl0 <= wr_data;
            end else if (wr_r1) begin
                ctl1 <= {wr_data[DW-1:B_TRG], 2'b00};
            end
        end
    end

    // Sticky overflow flag: set wins over read-clear, soft reset wins over both.
    always_ff @(posedge clk) begin
        if (!rst_n || do_rst) ovf_flag <= 1'b0;
        else                  ovf_flag <= ovf_evt | (ovf_flag & ~flag_clr);
    end

    // Count cycles after any reset before samples may be written.
    always_ff @(posedge clk) begin
        if (!rst_n || do_rst) cnt <= '0;
        else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end

    assign samp_en = (cnt == CNT_TOP);

    a_r4_soft_restore: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_clr |-> (ctl0 == '0 && ctl1 == CTL1_INIT && !ovf_flag));
    a_r5_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> !ptr_clr);
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_flag) && !$past(flag_clr) && !$past(do_rst)) |-> ovf_flag);
    a_r9_wait_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_clr |-> !samp_en);
    a_r4_cmd_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1[B_FLG:B_RST] == 2'b00);
endmodule

// File: rtl/cvh_read_path.sv
// Read path: picks what a read returns (sample word, register 0, register 1
// with the overflow flag), steps the debug readback sequence, issues the
// flag clear and the buffer pop at the end of each read.
// Assumes rd_end follows a run of rd_act cycles and hold_addr is the
// address of that read.
module cvh_read_path
    import cvh_pkg::*;
#(
    parameter int DW = CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_en,
    input  logic          dbg_arm,
    input  logic          rd_act,
    input  logic          rd_end,
    input  logic          addr,
    input  logic          hold_addr,
    input  logic [DW-1:0] ctl0,
    input  logic [DW-1:0] ctl1,
    input  logic          ovf_flag,
    input  logic [DW-1:0] sample_in,
    output logic [DW-1:0] rdata,
    output logic          flag_clr,
    output logic          sample_pop
);
    logic [1:0] phase;
    view_t      live_v;
    view_t      end_v;

    // Choose the source for a read given an address and the debug phase.
    function automatic view_t pick(input logic a, input logic dbg, input logic [1:0] ph);
        if (dbg && ph == 2'd0)      return V_REG0;
        else if (dbg && ph == 2'd1) return V_REG1;
        else if (a)                 return V_REG1;
        else                        return V_SAMPLE;
    endfunction

    // Source for the active read and for the read that just ended.
    always_comb begin
        live_v = pick(addr, dbg_en, phase);
        end_v  = pick(hold_addr, dbg_en, phase);
    end

    // Drive read data only while a read is active.
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            case (live_v)
                V_REG0:  rdata = ctl0;
                V_REG1:  rdata = ctl1 | (DW'(ovf_flag) << B_FLG);
                default: rdata = sample_in;
            endcase
        end
    end

    assign flag_clr = rd_end & (end_v == V_REG1);

    // Step the debug readback sequence; a register-1 write restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || dbg_arm)                      phase <= 2'd0;
        else if (rd_end && dbg_en && phase != 2'd2) phase <= phase + 2'd1;
    end

    // Pop the buffer after a completed sample read.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_pop <= 1'b0;
        else        sample_pop <= rd_end & (end_v == V_SAMPLE);
    end

    a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);
    a_r7_pop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pop |-> $past(rd_end));
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> rdata == '0);
endmodule

// File: rtl/cvh_host_ctrl.sv
// Top: host control register interface for a sampling converter.
// Connects the bus decoder, the register file and the read path, and fans
// register 1 out as named control fields.
// Assumes all host signals are synchronous to clk.
module cvh_host_ctrl
    import cvh_pkg::*;
#(
    parameter int DW         = CW,
    parameter int START_WAIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          ovf_evt,
    input  logic [DW-1:0] sample_in,
    output logic          sample_pop,
    output logic          ptr_clr,
    output logic          ofs_clr,
    output logic          samp_en,
    output logic [DW-1:0] ctl0,
    output logic [1:0]    trig_lvl,
    output logic          av_pulse,
    output logic          av_high,
    output logic          rw_mode,
    output logic          bin_fmt,
    output logic          ofs_cal,
    output logic          dbg_en
);
    logic          rd_act;
    logic          rd_end;
    logic          wr_end;
    logic          hold_addr;
    logic [DW-1:0] hold_data;
    logic [DW-1:0] ctl1;
    logic          ovf_flag;
    logic          flag_clr;
    logic          dbg_arm;

    cvh_bus_decode #(.DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .rw_mode(rw_mode),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .rd_act(rd_act), .rd_end(rd_end), .wr_end(wr_end),
        .hold_addr(hold_addr), .hold_data(hold_data)
    );

    cvh_ctrl_regs #(.DW(DW), .START_WAIT(START_WAIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .wr_addr(hold_addr),
        .wr_data(hold_data), .ovf_evt(ovf_evt), .flag_clr(flag_clr),
        .ctl0(ctl0), .ctl1(ctl1), .ovf_flag(ovf_flag),
        .ptr_clr(ptr_clr), .ofs_clr(ofs_clr), .samp_en(samp_en)
    );

    // Any committed register-1 write restarts the debug readback sequence.
    assign dbg_arm = wr_end & hold_addr;

    cvh_read_path #(.DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .dbg_arm(dbg_arm),
        .rd_act(rd_act), .rd_end(rd_end), .addr(addr), .hold_addr(hold_addr),
        .ctl0(ctl0), .ctl1(ctl1), .ovf_flag(ovf_flag), .sample_in(sample_in),
        .rdata(rdata), .flag_clr(flag_clr), .sample_pop(sample_pop)
    );

    // Named control fields of register 1.
    always_comb begin
        trig_lvl = ctl1[B_TRG+1:B_TRG];
        av_pulse = ctl1[B_PLS];
        av_high  = ctl1[B_POL];
        rw_mode  = ctl1[B_RWM];
        bin_fmt  = ctl1[B_FMT];
        ofs_cal  = ctl1[B_CAL];
        dbg_en   = ctl1[B_DBG];
    end
endmodule

// File: tb/tb_cvh_host_ctrl.sv
// Directed bench for cvh_host_ctrl: one task per scenario, inputs driven on
// the falling edge, outputs sampled on the falling edge.
module tb_cvh_host_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
    logic [9:0] wdata = '0;
    logic [9:0] rdata;
    logic       ovf_evt = 1'b0;
    logic [9:0] sample_in = 10'h2A5;
    logic       sample_pop, ptr_clr, ofs_clr, samp_en;
    logic [9:0] ctl0;
    logic [1:0] trig_lvl;
    logic       av_pulse, av_high, rw_mode, bin_fmt, ofs_cal, dbg_en;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         rwm = 1'b0;

    always #4 clk = ~clk;

    cvh_host_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ovf_evt(ovf_evt),
        .sample_in(sample_in), .sample_pop(sample_pop), .ptr_clr(ptr_clr),
        .ofs_clr(ofs_clr), .samp_en(samp_en), .ctl0(ctl0), .trig_lvl(trig_lvl),
        .av_pulse(av_pulse), .av_high(av_high), .rw_mode(rw_mode),
        .bin_fmt(bin_fmt), .ofs_cal(ofs_cal), .dbg_en(dbg_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One write: one active cycle, then raise write strobe and chip select.
    task automatic bus_wr(input logic a, input logic [9:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    // One read: rdata sampled mid-access; returns at the negedge after completion.
    task automatic bus_rd(input logic a, output logic [9:0] v);
        @(negedge clk);
        cs_n = 1'b0; addr = a;
        if (rwm) wr_n = 1'b1; else rd_n = 1'b0;
        #1 v = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [9:0] v;
        chk("R1 ctl0", ctl0, 10'h000);
        chk("R1 fields", {dbg_en, ofs_cal, bin_fmt, rw_mode, av_high, av_pulse, trig_lvl},
            8'b0000_1100);
        chk("R1 idle rdata", rdata, 10'h000);
        bus_rd(1'b1, v);
        chk("R1 reg1 read", v, 10'h030);
    endtask

    task automatic t_start_delay();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 samp_en in reset", samp_en, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 samp_en after 4 edges", samp_en, 1'b0);
        @(negedge clk);
        chk("R9 samp_en after 5 edges", samp_en, 1'b1);
    endtask

    task automatic t_sep_write();
        logic [9:0] v;
        bus_wr(1'b0, 10'h3C7);
        chk("R2 ctl0 write", ctl0, 10'h3C7);
        bus_wr(1'b1, 10'h18C);
        chk("R2 fields", {dbg_en, ofs_cal, bin_fmt, rw_mode, av_high, av_pulse, trig_lvl},
            8'b0110_0011);
        bus_rd(1'b1, v);
        chk("R2 reg1 readback", v, 10'h18C);
        // strobe rises while chip select stays low
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 1'b0; wdata = 10'h05A;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        chk("R2 commit on strobe rise", ctl0, 10'h05A);
        cs_n = 1'b1;
        @(negedge clk);
        bus_wr(1'b1, 10'h030);
    endtask

    task automatic t_buf_clear();
        logic [9:0] v;
        bus_wr(1'b1, 10'h0B2);
        chk("R5 ptr_clr pulse", ptr_clr, 1'b1);
        chk("R5 no ofs_clr", ofs_clr, 1'b0);
        chk("R5 bits stored", bin_fmt, 1'b1);
        @(negedge clk);
        chk("R5 ptr_clr single", ptr_clr, 1'b0);
        bus_rd(1'b1, v);
        chk("R5 bit1 not stored", v, 10'h0B0);
    endtask

    task automatic t_overflow();
        logic [9:0] v;
        @(negedge clk); ovf_evt = 1'b1;
        @(negedge clk); ovf_evt = 1'b0;
        bus_rd(1'b1, v);
        chk("R6 flag set", v[1], 1'b1);
        chk("R10 no pop on reg read", sample_pop, 1'b0);
        bus_rd(1'b1, v);
        chk("R6 flag cleared by read", v[1], 1'b0);
        // overflow on the same edge as a register-1 read completes
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 1'b1;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; ovf_evt = 1'b1;
        @(negedge clk); ovf_evt = 1'b0;
        bus_rd(1'b1, v);
        chk("R6 set wins over clear", v[1], 1'b1);
    endtask

    task automatic t_sample_read();
        logic [9:0] v;
        sample_in = 10'h2A5;
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 1'b0;
        #1 v = rdata;
        chk("R7 sample data", v, 10'h2A5);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        chk("R7 no pop during read", sample_pop, 1'b0);
        @(negedge clk);
        chk("R7 pop after read", sample_pop, 1'b1);
        @(negedge clk);
        chk("R7 pop single", sample_pop, 1'b0);
    endtask

    task automatic t_debug();
        logic [9:0] v;
        bus_wr(1'b0, 10'h155);
        bus_wr(1'b1, 10'h2B0);
        bus_rd(1'b0, v);
        chk("R8 first read reg0", v, 10'h155);
        chk("R10 no pop debug read", sample_pop, 1'b0);
        bus_rd(1'b0, v);
        chk("R8 second read reg1", v, 10'h2B0);
        bus_rd(1'b0, v);
        chk("R8 third read sample", v, 10'h2A5);
        chk("R8 third read pops", sample_pop, 1'b1);
        bus_wr(1'b1, 10'h2B0);
        bus_rd(1'b1, v);
        chk("R8 rearm returns reg0", v, 10'h155);
    endtask

    task automatic t_soft_reset();
        logic [9:0] v;
        @(negedge clk); ovf_evt = 1'b1;
        @(negedge clk); ovf_evt = 1'b0;
        bus_wr(1'b1, 10'h3FD);
        chk("R4 ptr_clr", ptr_clr, 1'b1);
        chk("R4 ofs_clr", ofs_clr, 1'b1);
        chk("R4 ctl0 cleared", ctl0, 10'h000);
        chk("R4 fields restored", {dbg_en, ofs_cal, bin_fmt, rw_mode, av_high, av_pulse, trig_lvl},
            8'b0000_1100);
        chk("R9 samp_en dropped", samp_en, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 samp_en 4 after soft", samp_en, 1'b0);
        @(negedge clk);
        chk("R9 samp_en 5 after soft", samp_en, 1'b1);
        bus_rd(1'b1, v);
        chk("R4 reg1 and flag restored", v, 10'h030);
    endtask

    task automatic t_rw_mode();
        logic [9:0] v;
        bus_wr(1'b1, 10'h070);
        chk("R3 mode on", rw_mode, 1'b1);
        rwm = 1'b1;
        @(negedge clk);
        rd_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0; addr = 1'b0; wdata = 10'h0AA;
        #1 chk("R3 rd_n ignored during write", rdata, 10'h000);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk("R3 write committed", ctl0, 10'h0AA);
        chk("R3 rd_n no pop", sample_pop, 1'b0);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        #1 chk("R10 rd_n alone idle", rdata, 10'h000);
        rd_n = 1'b1;
        bus_rd(1'b1, v);
        chk("R3 read via wr_n high", v, 10'h070);
        bus_rd(1'b0, v);
        chk("R3 sample read", v, 10'h2A5);
        chk("R3 pop after read", sample_pop, 1'b1);
        bus_wr(1'b1, 10'h030);
        rwm = 1'b0;
        chk("R3 mode off", rw_mode, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_start_delay();
        t_reset_state();
        t_sep_write();
        t_buf_clear();
        t_overflow();
        t_sample_read();
        t_debug();
        t_soft_reset();
        t_rw_mode();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule